// File: doc/BRIEF.md
# Manchester Line Codec

This block turns a stream of NRZ bits into a Manchester-coded serial line, and turns an oversampled Manchester line back into NRZ bits. One clock runs both directions at `OSR` times the bit rate (8 by default, so 80 MHz for a 10 Mb/s line). A bit cell lasts `OSR` clocks, and each half-cell lasts `OSR/2` clocks. The transmit side sends bits only while the link is reported good. It closes every frame with a fixed end pattern and then releases the line driver.

The receive side takes a line that an upstream slicer has already reduced to logic levels. It samples this line once per clock. It locks onto the transitions in the middle of each bit cell using a small phase counter, and it re-centres that counter on every accepted mid-cell edge. When the mid-cell edges stop, the carrier indication drops and a one-cycle end-of-frame pulse is produced.

Transmit data enters through a valid/ready pair. `tx_req` is the valid signal. A bit is taken on a clock where both `tx_req` and `tx_ready` are high. `tx_ready` rises for exactly one clock per bit cell, in the last clock of the cell, or at once when the encoder is idle. This is the only back-pressure: the source must hold `tx_bit` steady until the bit is taken. Receive data leaves as a one-cycle `rx_valid` strobe with no ready signal, because the line cannot be stalled. A frame must start with a 1 followed by a 0. The decoder uses the first bit of each frame to acquire phase and does not deliver it.

Top module: `manch_codec`

## Requirements
- R1: While `rst` is high and after it is released, `tx_oe` is 0, `tx_line` is 1, and `rx_carrier`, `rx_valid` and `rx_frame_end` are 0.
- R2: `tx_ready` is never high while `link_ok` is low. With `link_ok` low, a raised `tx_req` starts no frame and `tx_oe` stays 0.
- R3: After a bit is taken, the next `OSR` clocks carry its cell with `tx_oe`=1. A 1 is sent as `OSR/2` clocks low, then `OSR/2` clocks high. A 0 is sent as high, then low.
- R4: If no bit is taken at the end of a cell, `tx_line` is held at 1 with `tx_oe`=1 for `2*OSR` clocks. After that, `tx_oe` falls and the line stays at 1. The last transition is therefore mid-cell for a final 1 and at the cell boundary for a final 0.
- R5: If `link_ok` is low in the last clock of a cell, no further bit is accepted and the frame closes as in R4, even with `tx_req` still high.
- R6: The decoder delivers every bit of a frame except the first, in order. Each bit is one `rx_valid` pulse, with `rx_bit` equal to the line level after the mid-cell edge (rising edge = 1). `rx_valid` is high only while `rx_carrier` is high.
- R7: An edge counts as mid-cell only if the phase counter places it between 3/8 and 5/8 of a cell after the boundary estimate, and at least half a cell after the previous accepted edge. Cell-boundary edges are ignored. A mid-cell edge displaced by one sample is still accepted.
- R8: `rx_carrier` rises with the first delivered bit. It falls, together with a single `rx_frame_end` pulse, no later than 1.5 bit times after the end of the last bit.
- R9: A lone one-sample glitch, or a burst of edges one sample apart, on an idle line does not raise `rx_carrier` and delivers no bit.
- R10: After a bit is taken, `tx_ready` stays low until the last clock of that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at OSR times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| tx_req | input | 1 | Transmit valid; also keeps the frame open |
| tx_bit | input | 1 | NRZ bit offered for transmission |
| tx_ready | output | 1 | Encoder takes `tx_bit` this clock if `tx_req` is high |
| link_ok | input | 1 | Link is good; transmission is allowed |
| tx_line | output | 1 | Manchester serial output |
| tx_oe | output | 1 | Line driver enable |
| rx_line | input | 1 | Sliced Manchester input, one sample per clock |
| rx_valid | output | 1 | One-cycle strobe: `rx_bit` holds a decoded bit |
| rx_bit | output | 1 | Decoded NRZ bit |
| rx_carrier | output | 1 | Receive carrier present |
| rx_frame_end | output | 1 | One-cycle pulse when the carrier drops |

## Verification
The hardest situation to reach from the ports is frame acquisition. A frame that starts with a 1 produces a cell-boundary edge first, and the decoder must throw that anchor away and re-anchor on the following mid-cell edge. A close second is a mid-cell edge that lands one sample early or late. Loopback frames exercise acquisition, runs of equal bits, and a final bit of either value. A separate injected line pattern moves individual mid-cell edges by plus and minus one sample and sends glitch bursts into an idle decoder.

// File: rtl/manch_pkg.sv
package manch_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_HOLD = 2'd2
  } tx_state_e;
endpackage

// File: rtl/mc_tx_enc.sv
module mc_tx_enc
  import manch_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_req,
  input  logic tx_bit,
  input  logic link_ok,
  output logic tx_ready,
  output logic tx_line,
  output logic tx_oe
);
  localparam int HALF = OSR / 2;
  localparam int HOLD = 2 * OSR;
  localparam int PW   = $clog2(HOLD);

  tx_state_e     st;
  logic [PW-1:0] ph;
  logic          cur_bit;
  logic          cell_end;
  logic          take;

  assign cell_end = (st == TX_DATA) && (ph == PW'(OSR - 1));
  assign tx_ready = link_ok && ((st == TX_IDLE) || cell_end);
  assign take     = tx_ready && tx_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TX_IDLE;
      ph      <= '0;
      cur_bit <= 1'b0;
    end else if (take) begin
      st      <= TX_DATA;
      ph      <= '0;
      cur_bit <= tx_bit;
    end else begin
      unique case (st)
        TX_DATA: begin
          ph <= cell_end ? '0 : ph + PW'(1);
          if (cell_end) st <= TX_HOLD;
        end
        TX_HOLD: begin
          if (ph == PW'(HOLD - 1)) begin
            st <= TX_IDLE;
            ph <= '0;
          end else begin
            ph <= ph + PW'(1);
          end
        end
        default: ph <= '0;
      endcase
    end
  end

  // first half carries the complement, second half the bit itself
  assign tx_line = (st == TX_DATA) ? ((ph < PW'(HALF)) ? ~cur_bit : cur_bit) : 1'b1;
  assign tx_oe   = (st != TX_IDLE);
endmodule

// File: rtl/mc_rx_edge.sv
module mc_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic lvl,
  output logic flip
);
  logic s0, s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0 <= 1'b1;
      s1 <= 1'b1;
    end else begin
      s0 <= line_in;
      s1 <= s0;
    end
  end

  assign lvl  = s0;
  assign flip = s0 ^ s1;
endmodule

// File: rtl/mc_rx_dec.sv
module mc_rx_dec #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic flip,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_carrier,
  output logic rx_frame_end
);
  localparam int HALF = OSR / 2;
  localparam int WLO  = (3 * OSR) / 8;
  localparam int WHI  = (5 * OSR) / 8;
  localparam int DROP = OSR + HALF;
  localparam int CW   = $clog2(OSR);
  localparam int QW   = $clog2(DROP + 1);

  logic [CW-1:0] phase;
  logic [QW-1:0] quiet;
  logic          in_win;
  logic          mid;
  logic          anchor;

  assign in_win = (phase >= CW'(WLO)) && (phase <= CW'(WHI));
  assign mid    = flip && in_win && (quiet >= QW'(HALF)) && (quiet < QW'(DROP));
  // unlocked: every edge becomes a fresh candidate anchor
  assign anchor = flip && (mid || !rx_carrier);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= '0;
      quiet        <= QW'(DROP);
      rx_carrier   <= 1'b0;
      rx_valid     <= 1'b0;
      rx_bit       <= 1'b0;
      rx_frame_end <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_end <= 1'b0;
      if (anchor) begin
        phase <= CW'(HALF + 1);
        quiet <= '0;
        if (mid) begin
          rx_carrier <= 1'b1;
          rx_valid   <= 1'b1;
          rx_bit     <= lvl;
        end
      end else begin
        phase <= (phase == CW'(OSR - 1)) ? '0 : phase + CW'(1);
        if (quiet != QW'(DROP)) quiet <= quiet + QW'(1);
        if (rx_carrier && (quiet == QW'(DROP - 1))) begin
          rx_carrier   <= 1'b0;
          rx_frame_end <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/manch_codec.sv
module manch_codec #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_req,
  input  logic tx_bit,
  output logic tx_ready,
  input  logic link_ok,
  output logic tx_line,
  output logic tx_oe,
  input  logic rx_line,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_carrier,
  output logic rx_frame_end
);
  logic samp_lvl;
  logic samp_flip;

  mc_tx_enc #(.OSR(OSR)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .tx_req   (tx_req),
    .tx_bit   (tx_bit),
    .link_ok  (link_ok),
    .tx_ready (tx_ready),
    .tx_line  (tx_line),
    .tx_oe    (tx_oe)
  );

  mc_rx_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .line_in (rx_line),
    .lvl     (samp_lvl),
    .flip    (samp_flip)
  );

  mc_rx_dec #(.OSR(OSR)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .lvl          (samp_lvl),
    .flip         (samp_flip),
    .rx_valid     (rx_valid),
    .rx_bit       (rx_bit),
    .rx_carrier   (rx_carrier),
    .rx_frame_end (rx_frame_end)
  );
endmodule

// File: rtl/manch_codec_chk.sv
module manch_codec_chk (
  input logic clk,
  input logic rst,
  input logic tx_req,
  input logic tx_ready,
  input logic link_ok,
  input logic tx_line,
  input logic tx_oe,
  input logic rx_valid,
  input logic rx_carrier,
  input logic rx_frame_end
);
  a_r2_ready_needs_link: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> link_ok);

  a_r10_one_take_per_cell: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && tx_req) |=> !tx_ready);

  a_r4_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> tx_line);

  a_r6_bits_under_carrier: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_carrier);

  a_r8_end_marks_carrier_fall: assert property (@(posedge clk) disable iff (rst)
    rx_frame_end |-> (!rx_carrier && $past(rx_carrier)));
endmodule

bind manch_codec manch_codec_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_req       (tx_req),
  .tx_ready     (tx_ready),
  .link_ok      (link_ok),
  .tx_line      (tx_line),
  .tx_oe        (tx_oe),
  .rx_valid     (rx_valid),
  .rx_carrier   (rx_carrier),
  .rx_frame_end (rx_frame_end)
);

// File: tb/sim_manch_codec.sv
module sim_manch_codec;
  localparam int OSR  = 8;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_req = 1'b0, tx_bit = 1'b0, link_ok = 1'b0;
  logic use_inj = 1'b0, inj = 1'b1;
  logic tx_ready, tx_line, tx_oe, rx_valid, rx_bit, rx_carrier, rx_frame_end;
  logic rx_in;
  int   n_chk = 0, n_bad = 0, cyc = 0, rx_n = 0, end_n = 0;
  logic rxb [64];

  assign rx_in = use_inj ? inj : tx_line;

  manch_codec #(.OSR(OSR)) u0 (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .link_ok(link_ok), .tx_line(tx_line), .tx_oe(tx_oe), .rx_line(rx_in),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_carrier(rx_carrier),
    .rx_frame_end(rx_frame_end)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_n < 64) rxb[rx_n] = rx_bit;
      rx_n = rx_n + 1;
    end
    if (rx_frame_end) end_n = end_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmp_bits(input logic [31:0] b, input int n, input string req);
    int bad = 0;
    chk(rx_n == n - 1, req, rx_n, n - 1);
    for (int i = 1; i < n; i++) if (i - 1 < rx_n && rxb[i-1] !== b[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // loopback frame, bit 0 sent first; optional link loss in last cell
  task automatic send_frame(input logic [31:0] b, input int n, input bit drop_link);
    int wave_bad = 0, rdy_bad = 0, cp = 0, fall;
    rx_n = 0; end_n = 0; use_inj = 1'b0;
    @(negedge clk);
    tx_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      tx_bit = b[i];
      while (!tx_ready) @(negedge clk);
      @(posedge clk); #1; cp = cyc;
      for (int j = 0; j < OSR; j++) begin
        @(negedge clk);
        if (tx_line !== ((j < HALF) ? ~b[i] : b[i]) || tx_oe !== 1'b1) wave_bad++;
        if (j < OSR - 1 && tx_ready) rdy_bad++;
        if (drop_link && i == n - 1 && j == 1) link_ok = 1'b0;
      end
    end
    if (drop_link) begin
      @(posedge clk); #1;
      chk(tx_ready == 1'b0, "R5 no take after link loss", tx_ready, 0);
    end
    tx_req = 1'b0;
    chk(wave_bad == 0, "R3 cell waveform", wave_bad, 0);
    chk(rdy_bad == 0, "R10 ready only at cell end", rdy_bad, 0);
    while (rx_carrier && cyc - cp < 60) @(negedge clk);
    fall = cyc - cp;
    // end of last bit is OSR clocks after its take; 1.5 bits more allowed
    chk(fall > OSR && fall <= 2 * OSR + HALF, "R8 carrier drop time", fall, OSR + 10);
    while (cyc - cp < 3 * OSR - 1) @(negedge clk);
    chk(tx_oe === 1'b1 && tx_line === 1'b1, "R4 end hold high", {tx_oe, tx_line}, 3);
    @(negedge clk);
    chk(tx_oe === 1'b0 && tx_line === 1'b1, "R4 driver released", {tx_oe, tx_line}, 1);
    chk(end_n == 1, "R8 single frame-end pulse", end_n, 1);
    cmp_bits(b, n, "R6 decoded bits");
    link_ok = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(tx_oe === 1'b0 && tx_line === 1'b1, "R1 tx in reset", {tx_oe, tx_line}, 1);
    chk({rx_carrier, rx_valid, rx_frame_end} === 3'b000, "R1 rx in reset",
        {rx_carrier, rx_valid, rx_frame_end}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_oe === 1'b0 && rx_carrier === 1'b0, "R1 after release", {tx_oe, rx_carrier}, 0);
  endtask

  task automatic t_no_link;
    int bad = 0;
    link_ok = 1'b0; tx_req = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tx_ready !== 1'b0 || tx_oe !== 1'b0) bad++;
    end
    tx_req = 1'b0;
    chk(bad == 0, "R2 link down blocks start", bad, 0);
    link_ok = 1'b1;
    @(negedge clk);
    chk(tx_ready === 1'b1, "R2 ready with link", tx_ready, 1);
  endtask

  // drive rx directly; dl[i] moves bit i's mid edge by +1, dr[i] by -1
  task automatic rx_jitter(input logic [31:0] b, input int n,
                           input logic [31:0] dl, input logic [31:0] dr);
    int split;
    rx_n = 0; end_n = 0; use_inj = 1'b1; inj = 1'b1;
    repeat (20) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      split = HALF + (dl[i] ? 1 : 0) - (dr[i] ? 1 : 0);
      for (int j = 0; j < OSR; j++) begin
        inj = (j < split) ? ~b[i] : b[i];
        @(negedge clk);
      end
    end
    inj = 1'b1;
    repeat (40) @(negedge clk);
    cmp_bits(b, n, "R7 jittered mid edges");
    chk(end_n == 1 && rx_carrier == 1'b0, "R8 carrier ends after jitter frame", end_n, 1);
  endtask

  task automatic t_glitch;
    rx_n = 0; use_inj = 1'b1; inj = 1'b1;
    repeat (20) @(negedge clk);
    inj = 1'b0; @(negedge clk); inj = 1'b1;
    repeat (30) @(negedge clk);
    chk(rx_carrier === 1'b0 && rx_n == 0, "R9 single glitch", rx_n, 0);
    for (int k = 0; k < 8; k++) begin
      inj = ~inj; @(negedge clk);
    end
    inj = 1'b1;
    repeat (30) @(negedge clk);
    chk(rx_carrier === 1'b0 && rx_n == 0, "R9 glitch burst", rx_n, 0);
    use_inj = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_link();
    // frame ending in 1: 1,0,1,0,1,1,0,0,1,0,1
    send_frame(32'b101_0011_0101, 11, 1'b0);
    // frame ending in 0: 1,0,1,0,0,0,1,1,0,1,0
    send_frame(32'b010_1100_0101, 11, 1'b0);
    // link lost during last cell of 1,0,1,1
    send_frame(32'b1101, 4, 1'b1);
    // 1,0,1,0,1,1,0,1,0 with bit5 late and bit7 early
    rx_jitter(32'b0_1011_0101, 9, 32'h20, 32'h80);
    t_glitch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule